// File: doc/BRIEF.md
# Serial Five-Write Register Loader

This block loads four 5-bit configuration registers of a memory-banking controller through a single serial data bit. It watches CPU bus cycles once per CPU clock. A write anywhere in the upper half of the address space (address bit 15 set) with data bit 7 clear feeds data bit 0 into a shift register, least significant bit first. The first four such writes only shift, and their address does not matter. The fifth write copies its own data bit 0, above the four shifted bits, into one of the four registers chosen by address bits 14:13. The shift register then empties itself.

A write into the same window with data bit 7 set abandons any partial load. It also forces bits 3:2 of the control register to ones, which pins the program-bank mode to "last bank fixed at the top". Full detection uses a sentinel 1 that travels down the shift register, so no separate bit counter exists.

A CPU read-modify-write instruction issues two writes on back-to-back cycles. To cope with this, a data-bit write is dropped whenever the cycle before it was a write cycle of any kind, even one below the window. A reset write is acted on even in that case. A two-state bus-history machine holds the one-cycle history. Its states are HIST_QUIET (the previous cycle was not a write) and HIST_WROTE (the previous cycle was a write). Every write cycle takes it to HIST_WROTE, and every non-write cycle takes it back to HIST_QUIET. A data-bit write is accepted only in HIST_QUIET.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset the control register reads 0x0C, the other three registers read 0, and the next five accepted data-bit writes form a complete load.
- R2: A write with address bit 15 set and data bit 7 set discards any partially collected bits, so the following five data-bit writes load a fresh value.
- R3: That reset write sets control bits 3:2 to 1 and leaves control bits 4 and 1:0 at their previous values. The other registers do not change.
- R4: Data bits are collected least significant bit first from data bit 0. Data bits 6:1 and the address of the first four writes have no effect.
- R5: The fifth accepted write stores {data bit 0, four collected bits} into the register selected by address bits 14:13: 00 control, 01 character bank 0, 10 character bank 1, 11 program bank. The other three registers keep their values. Outputs update one clock after the write cycle.
- R6: After a fifth write the collector is empty again, so loads may follow one another without a reset write.
- R7: A data-bit write on the cycle directly after a write cycle is ignored. In a run of three or more back-to-back writes, only the first one counts.
- R8: A reset write is honoured even on the cycle directly after another write.
- R9: A write below the window (address bit 15 clear) also marks the next cycle as following a write, so a data-bit write on that next cycle is ignored.
- R10: Read cycles, and writes with address bit 15 clear, change no register and no collected bit, whatever their data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock, one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ctrl_reg | output | 5 | Control register (mirroring, program mode, character mode) |
| chr0_reg | output | 5 | Character bank 0 register |
| chr1_reg | output | 5 | Character bank 1 register |
| prg_reg | output | 5 | Program bank register |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data bus, 5-bit registers and a control reset value of 0x0C. With these values the whole address space is reachable. That lets writes below the window be driven right before window writes, which exercises R9. It also lets all four select codes and the two-bit forced mode field be hit directly. With the 5-bit register width, the sentinel reaches the low position after exactly four shifts, so the commit cycle can be placed precisely. The random phase mixes reads, writes below the window, rare reset writes and frequent back-to-back writes.

// File: rtl/loader_pkg.sv
package loader_pkg;

    // One-cycle bus history used to drop back-to-back writes
    typedef enum logic {
        HIST_QUIET = 1'b0,
        HIST_WROTE = 1'b1
    } hist_t;

    // Destination chosen by the upper address select bits on the fifth write
    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_CHR0 = 2'b01,
        SEL_CHR1 = 2'b10,
        SEL_PRG  = 2'b11
    } regsel_t;

endpackage

// File: rtl/bus_history.sv
module bus_history
    import loader_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cycle,
    output logic accept
);

    hist_t state_q;
    hist_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HIST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: any write cycle marks the next cycle as following a write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HIST_QUIET: if (wr_cycle)  state_d = HIST_WROTE;
            HIST_WROTE: if (!wr_cycle) state_d = HIST_QUIET;
        endcase
    end

    // Output: a write counts only when the previous cycle was not a write
    always_comb begin
        accept = 1'b0;
        unique case (state_q)
            HIST_QUIET: accept = wr_cycle;
            HIST_WROTE: accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/sentinel_shifter.sv
module sentinel_shifter #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic             full,
    output logic [REG_W-2:0] collected
);

    localparam logic [REG_W-1:0] EMPTY = {1'b1, {(REG_W-1){1'b0}}};

    logic [REG_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= EMPTY;
        end else if (clear) begin
            sr_q <= EMPTY;
        end else if (shift_en) begin
            if (sr_q[0]) begin
                sr_q <= EMPTY;
            end else begin
                sr_q <= {din, sr_q[REG_W-1:1]};
            end
        end
    end

    assign full      = sr_q[0];
    assign collected = sr_q[REG_W-1:1];

endmodule

// File: rtl/reg_file.sv
module reg_file #(
    parameter int               REG_W      = 5,
    parameter int               NUM_REGS   = 4,
    parameter logic [REG_W-1:0] CTRL_INIT  = 5'h0C,
    parameter logic [REG_W-1:0] FORCE_MASK = 5'h0C
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [$clog2(NUM_REGS)-1:0]       sel,
    input  logic [REG_W-1:0]                  value,
    input  logic                              force_mode,
    output logic [NUM_REGS-1:0][REG_W-1:0]    regs_q
);

    localparam int SEL_W = $clog2(NUM_REGS);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] INIT = (i == 0) ? CTRL_INIT : '0;
        localparam logic [SEL_W-1:0] IDX  = SEL_W'(i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= INIT;
            end else if ((i == 0) && force_mode) begin
                regs_q[i] <= regs_q[i] | FORCE_MASK;
            end else if (commit && (sel == IDX)) begin
                regs_q[i] <= value;
            end
        end
    end

endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
    import loader_pkg::*;
#(
    parameter int               ADDR_W     = 16,
    parameter int               DATA_W     = 8,
    parameter int               REG_W      = 5,
    parameter logic [REG_W-1:0] CTRL_INIT  = 5'h0C,
    parameter logic [REG_W-1:0] FORCE_MASK = 5'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rnw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic [REG_W-1:0]  ctrl_reg,
    output logic [REG_W-1:0]  chr0_reg,
    output logic [REG_W-1:0]  chr1_reg,
    output logic [REG_W-1:0]  prg_reg
);

    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int WIN_BIT   = ADDR_W - 1;
    localparam int SEL_HI    = ADDR_W - 2;
    localparam int SEL_LO    = ADDR_W - 1 - SEL_W;
    localparam int RESET_BIT = DATA_W - 1;

    logic                           wr_cycle;
    logic                           in_window;
    logic                           reset_wr;
    logic                           accept;
    logic                           data_wr;
    logic                           full;
    logic                           commit;
    logic [REG_W-2:0]               collected;
    logic [REG_W-1:0]               value;
    logic [SEL_W-1:0]               sel;
    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
    logic                           unused_bits;

    assign wr_cycle  = ~cpu_rnw;
    assign in_window = wr_cycle & cpu_addr[WIN_BIT];
    assign reset_wr  = in_window & cpu_data[RESET_BIT];
    assign data_wr   = in_window & ~cpu_data[RESET_BIT] & accept;
    assign commit    = data_wr & full;
    assign value     = {cpu_data[0], collected};
    assign sel       = cpu_addr[SEL_HI:SEL_LO];

    assign unused_bits = ^{cpu_addr[SEL_LO-1:0], cpu_data[RESET_BIT-1:1]};

    bus_history u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cycle (wr_cycle),
        .accept   (accept)
    );

    sentinel_shifter #(
        .REG_W (REG_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (reset_wr),
        .shift_en  (data_wr),
        .din       (cpu_data[0]),
        .full      (full),
        .collected (collected)
    );

    reg_file #(
        .REG_W      (REG_W),
        .NUM_REGS   (NUM_REGS),
        .CTRL_INIT  (CTRL_INIT),
        .FORCE_MASK (FORCE_MASK)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .sel        (sel),
        .value      (value),
        .force_mode (reset_wr),
        .regs_q     (regs_q)
    );

    assign ctrl_reg = regs_q[SEL_CTRL];
    assign chr0_reg = regs_q[SEL_CHR0];
    assign chr1_reg = regs_q[SEL_CHR1];
    assign prg_reg  = regs_q[SEL_PRG];

endmodule

// File: rtl/serial_reg_loader_chk.sv
module serial_reg_loader_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int REG_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rnw,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic [REG_W-1:0]  ctrl_reg,
    input logic [REG_W-1:0]  chr0_reg,
    input logic [REG_W-1:0]  chr1_reg,
    input logic [REG_W-1:0]  prg_reg
);

    logic prev_wr;
    logic hit_win;
    logic hit_rst;
    logic [4*REG_W-1:0] all_regs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_wr <= 1'b0;
        else        prev_wr <= ~cpu_rnw;
    end

    assign hit_win  = ~cpu_rnw & cpu_addr[ADDR_W-1];
    assign hit_rst  = hit_win & cpu_data[DATA_W-1];
    assign all_regs = {ctrl_reg, chr0_reg, chr1_reg, prg_reg};

    // R3
    ctrl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rst |=> (ctrl_reg[3:2] == 2'b11) && (ctrl_reg[4] == $past(ctrl_reg[4]))
                    && (ctrl_reg[1:0] == $past(ctrl_reg[1:0])));

    // R8
    late_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_wr && hit_rst) |=> (ctrl_reg[3:2] == 2'b11));

    // R7
    rmw_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_wr && !cpu_rnw && !cpu_data[DATA_W-1]) |=> $stable(all_regs));

    // R10
    outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rnw || !cpu_addr[ADDR_W-1]) |=> $stable(all_regs));

    // R5
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_win && !cpu_data[DATA_W-1]) |=>
        ($countones({ctrl_reg != $past(ctrl_reg), chr0_reg != $past(chr0_reg),
                     chr1_reg != $past(chr1_reg), prg_reg != $past(prg_reg)}) <= 1));

endmodule

bind serial_reg_loader serial_reg_loader_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_rnw  (cpu_rnw),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .ctrl_reg (ctrl_reg),
    .chr0_reg (chr0_reg),
    .chr1_reg (chr1_reg),
    .prg_reg  (prg_reg)
);

// File: tb/serial_reg_loader_test.sv
module serial_reg_loader_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rnw = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [4:0]  ctrl_reg, chr0_reg, chr1_reg, prg_reg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state (count + accumulator, not a sentinel)
    int       m_cnt;
    logic [4:0] m_acc;
    logic     m_prev;
    logic [4:0] m_reg [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_reg_loader uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_rnw  (cpu_rnw),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .ctrl_reg (ctrl_reg),
        .chr0_reg (chr0_reg),
        .chr1_reg (chr1_reg),
        .prg_reg  (prg_reg)
    );

    function automatic logic [19:0] pack(input logic [4:0] c, input logic [4:0] a,
                                         input logic [4:0] b, input logic [4:0] p);
        return {c, a, b, p};
    endfunction

    function automatic logic [19:0] model_regs();
        return {m_reg[0], m_reg[1], m_reg[2], m_reg[3]};
    endfunction

    task automatic model_reset();
        m_cnt = 0;
        m_acc = '0;
        m_prev = 1'b0;
        m_reg[0] = 5'h0C;
        m_reg[1] = '0;
        m_reg[2] = '0;
        m_reg[3] = '0;
    endtask

    task automatic model_step(input logic rnw, input logic [15:0] a, input logic [7:0] d);
        if (!rnw && a[15]) begin
            if (d[7]) begin
                m_cnt = 0;
                m_acc = '0;
                m_reg[0] = m_reg[0] | 5'h0C;
            end else if (!m_prev) begin
                m_acc[m_cnt] = d[0];
                if (m_cnt == 4) begin
                    m_reg[a[14:13]] = m_acc;
                    m_cnt = 0;
                    m_acc = '0;
                end else begin
                    m_cnt++;
                end
            end
        end
        m_prev = !rnw;
    endtask

    function automatic logic [19:0] dut_regs();
        return {ctrl_reg, chr0_reg, chr1_reg, prg_reg};
    endfunction

    task automatic check(input string tag, input logic [19:0] exp);
        n_cmp++;
        if (dut_regs() !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, dut_regs(), exp);
        end
    endtask

    // One bus cycle: drive at falling edge, model at rising edge, settle after
    task automatic bus(input logic rnw, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_rnw  = rnw;
        cpu_addr = a;
        cpu_data = d;
        @(posedge clk);
        model_step(rnw, a, d);
        #(CLK_PERIOD/4);
    endtask

    task automatic idle();
        bus(1'b1, 16'h0000, 8'h00);
    endtask

    // Five spaced writes; first four go to unrelated window addresses
    task automatic load_reg(input logic [15:0] dest, input logic [4:0] v);
        for (int i = 0; i < 5; i++) begin
            logic [15:0] a;
            a = (i < 4) ? {1'b1, 2'(3 - i), 13'h0ABC} : dest;
            bus(1'b0, a, {1'b0, 6'b101010, v[i]});
            idle();
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1 reset values
        check("R1 reset", pack(5'h0C, 5'h00, 5'h00, 5'h00));

        // R4 R5 loads into each register
        load_reg(16'h8000, 5'h13);
        check("R4 R5 control load", pack(5'h13, 5'h00, 5'h00, 5'h00));
        load_reg(16'hA000, 5'h15);
        check("R5 chr0 load", pack(5'h13, 5'h15, 5'h00, 5'h00));
        load_reg(16'hC000, 5'h0A);
        check("R5 chr1 load", pack(5'h13, 5'h15, 5'h0A, 5'h00));
        load_reg(16'hE000, 5'h1F);
        check("R5 prg load", pack(5'h13, 5'h15, 5'h0A, 5'h1F));

        // R6 back-to-back loads without reset write
        load_reg(16'hE000, 5'h03);
        check("R6 first load", pack(5'h13, 5'h15, 5'h0A, 5'h03));
        load_reg(16'hF5A5, 5'h1C);
        check("R6 second load", pack(5'h13, 5'h15, 5'h0A, 5'h1C));

        // R2 R3 partial load then reset write
        bus(1'b0, 16'h8000, 8'h01); idle();
        bus(1'b0, 16'h8000, 8'h01); idle();
        bus(1'b0, 16'hFFFF, 8'h80); idle();
        check("R3 force mode bits", pack(5'h1F, 5'h15, 5'h0A, 5'h1C));
        load_reg(16'h8000, 5'h01);
        check("R2 fresh load after reset write", pack(5'h01, 5'h15, 5'h0A, 5'h1C));
        bus(1'b0, 16'h9000, 8'hC0); idle();
        check("R3 or keeps low bits", pack(5'h0D, 5'h15, 5'h0A, 5'h1C));

        // R7 doubled writes, one tripled
        for (int i = 0; i < 5; i++) begin
            logic [4:0] v;
            v = 5'h06;
            bus(1'b0, 16'h8000, {7'b0, v[i]});
            bus(1'b0, 16'h8000, {7'b0, ~v[i]});
            if (i == 2) bus(1'b0, 16'h8000, {7'b0, ~v[i]});
            idle();
        end
        check("R7 consecutive writes ignored", pack(5'h06, 5'h15, 5'h0A, 5'h1C));

        // R9 write below window suppresses the next cycle
        bus(1'b0, 16'hE000, 8'h01); idle();
        bus(1'b0, 16'hE000, 8'h00); idle();
        bus(1'b0, 16'hE000, 8'h01); idle();
        bus(1'b0, 16'hE000, 8'h00); idle();
        bus(1'b0, 16'h6000, 8'h00);
        bus(1'b0, 16'hE000, 8'h01);
        idle();
        check("R9 write after low write ignored", pack(5'h06, 5'h15, 5'h0A, 5'h1C));
        bus(1'b0, 16'hE000, 8'h00); idle();
        check("R9 real fifth write", pack(5'h06, 5'h15, 5'h0A, 5'h05));

        // R8 reset write directly after a write
        bus(1'b0, 16'h8000, 8'h00);
        bus(1'b0, 16'h8000, 8'h80);
        idle();
        check("R8 late reset honoured", pack(5'h0E, 5'h15, 5'h0A, 5'h05));
        load_reg(16'h8000, 5'h10);
        check("R8 collector cleared", pack(5'h10, 5'h15, 5'h0A, 5'h05));

        // R10 reads and low writes have no effect
        bus(1'b0, 16'h7FFF, 8'h80); idle();
        bus(1'b1, 16'h8000, 8'h80); idle();
        check("R10 no effect outside window", pack(5'h10, 5'h15, 5'h0A, 5'h05));
        for (int i = 0; i < 5; i++) begin
            logic [4:0] v;
            v = 5'h07;
            bus(1'b0, 16'h4000, 8'h01); idle();
            bus(1'b0, 16'hA000, {7'b0, v[i]});
            bus(1'b1, 16'hA000, 8'hFF);
        end
        idle();
        check("R10 interleaved traffic", pack(5'h10, 5'h07, 5'h0A, 5'h05));

        // Random phase against the reference model
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [15:0] a;
            logic [7:0]  d;
            r = $urandom % 100;
            a = 16'($urandom);
            d = 8'($urandom);
            if (r < 40) begin
                bus(1'b1, a, d);
            end else if (r < 52) begin
                bus(1'b0, a & 16'h7FFF, d);
            end else begin
                if (($urandom % 20) != 0) d[7] = 1'b0;
                bus(1'b0, a | 16'h8000, d);
            end
            check("R5 R7 random", model_regs());
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule